// File: doc/BRIEF.md
# Exception Entry Unit

This block sends a small processor into its privileged firmware mode when an exception or trap is taken. It accepts a request made of a cause code and, for call-gate traps, an 8-bit gate number. From these it works out the firmware entry address as an offset added to a firmware base register. It records the return address with the old mode flag packed into bit 0, and it sets the privileged-mode flag.

The first entry from unprivileged mode also exchanges eight live integer registers with an internal bank of eight shadow registers. This happens in one cycle through a lane-wise exchange port. Lane k (k = 0..6) maps to integer register 8+k and lane 7 maps to register 25. An entry taken while already privileged leaves the mode flag and the shadow bank alone. A cause code outside the defined set raises a sticky error and commits nothing. The return path clears the mode flag through a single clear input.

Top module: `exc_entry_unit`

## Requirements
- R1: Cause codes 0..9 (reset, machine check, interprocessor interrupt, clock interrupt, device interrupt, memory fault, unaligned access, illegal opcode, arithmetic trap, FP disabled) enter at `fw_base + code*0x80`.
- R2: Cause code 10 (call gate) with gate bit 7 clear enters at `fw_base + 0x1000 + gate*64`.
- R3: Cause code 10 with gate bit 7 set enters at `fw_base + 0x2000 + (gate-0x80)*64`.
- R4: On a handled entry, `saved_pc` becomes `cur_pc` with bit 0 ORed with the privileged flag as it stood before the entry.
- R5: A handled entry taken while `priv_mode` is 0 sets `priv_mode`. It asserts `live_we` for exactly one cycle, with `live_wr` lane k carrying shadow slot k. In that same cycle it loads shadow slot k from `live_rd` lane k. `swap_idx` lane k reads 8+k for k<7 and 25 for lane 7, in 5-bit fields.
- R6: A handled entry taken while `priv_mode` is 1 asserts no `live_we`, leaves the shadow bank as it was, and keeps `priv_mode` at 1.
- R7: Codes 11..15 set `unhandled_err`, which stays set until reset. Such an entry leaves `new_pc`, `saved_pc`, `priv_mode` and the shadow bank unchanged, and it still pulses `entry_done`.
- R8: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 for the cycle after the accept. `entry_done` is 1 for exactly the single cycle that follows the second edge after the accept, and the results are valid in that cycle.
- R9: After reset: `req_ready`=1, `priv_mode`=0, `unhandled_err`=0, `entry_done`=0, `live_we`=0, `new_pc`=0, `saved_pc`=0, and all shadow slots are zero.
- R10: A one-cycle `mode_clear` with no entry committing clears `priv_mode` at the next edge, and the next handled entry swaps again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exception request present |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_code | input | 4 | Cause code |
| req_gate | input | 8 | Call-gate number (code 10) |
| cur_pc | input | PC_W | PC of the trapping point |
| fw_base | input | PC_W | Firmware base register |
| mode_clear | input | 1 | Clear privileged flag (return path) |
| live_rd | input | LANES*DATA_W | Current values of the eight banked registers |
| live_wr | output | LANES*DATA_W | Values written into the banked registers |
| live_we | output | 1 | Exchange strobe to the register file |
| swap_idx | output | LANES*5 | Register index of each lane |
| new_pc | output | PC_W | Entry address |
| saved_pc | output | PC_W | Saved return address with mode bit |
| priv_mode | output | 1 | Privileged-mode flag |
| entry_done | output | 1 | Entry finished pulse |
| unhandled_err | output | 1 | Sticky unhandled-cause flag |

## Verification
The exchange strobe is due one edge after the accept edge, and `new_pc`, `saved_pc`, `priv_mode` and the error flag are due one edge later, together with `entry_done`. When the driver issues a request, the scoreboard stores the cycle number at which `entry_done` is expected. Outputs are sampled on the falling edge. The exchange data is captured in the cycle `live_we` is high and compared when the matching done pulse arrives. `req_ready` is checked low in the cycle after each accept, and back-to-back requests show that a request held during that cycle is only taken once the unit is idle.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int CODE_W = 4;
  localparam int GATE_W = 8;
  localparam int OFF_W  = 14;
  localparam int IDX_W  = 5;
  localparam int SLOT_SHIFT = 6;
  localparam int VEC_SHIFT  = 7;

  typedef enum logic [CODE_W-1:0] {
    EC_RESET   = 4'd0,
    EC_MCHK    = 4'd1,
    EC_IPI     = 4'd2,
    EC_CLOCK   = 4'd3,
    EC_DEVICE  = 4'd4,
    EC_MEMFLT  = 4'd5,
    EC_UNALIGN = 4'd6,
    EC_BADOP   = 4'd7,
    EC_ARITH   = 4'd8,
    EC_FPOFF   = 4'd9,
    EC_GATE    = 4'd10
  } exc_code_e;

  function automatic logic code_known(input logic [CODE_W-1:0] c);
    return c <= EC_GATE;
  endfunction

  // Fixed vectors sit on 128-byte steps
  function automatic logic [OFF_W-1:0] fixed_offset(input logic [CODE_W-1:0] c);
    return OFF_W'(c) << VEC_SHIFT;
  endfunction

  // Gate slots: 64 bytes each, privileged bank at 0x1000, user bank at 0x2000
  function automatic logic [OFF_W-1:0] gate_offset(input logic [GATE_W-1:0] g);
    logic [OFF_W-1:0] slot;
    slot = OFF_W'(g[GATE_W-2:0]) << SLOT_SHIFT;
    return g[GATE_W-1] ? (OFF_W'(14'h2000) + slot) : (OFF_W'(14'h1000) + slot);
  endfunction

  // Lane k maps to integer register 8+k, the last lane to register 25
  function automatic logic [IDX_W-1:0] lane_reg(input int k);
    return (k < 7) ? IDX_W'(8 + k) : IDX_W'(25);
  endfunction
endpackage

// File: rtl/exc_vector_calc.sv
module exc_vector_calc
  import exc_entry_pkg::*;
#(
  parameter int PC_W = 64
) (
  input  logic [CODE_W-1:0] code,
  input  logic [GATE_W-1:0] gate,
  input  logic [PC_W-1:0]   base,
  output logic [PC_W-1:0]   target,
  output logic              known
);
  logic [OFF_W-1:0] offset;

  always_comb begin
    known  = code_known(code);
    offset = (code == EC_GATE) ? gate_offset(gate) : fixed_offset(code);
    target = base + PC_W'(offset);
  end
endmodule

// File: rtl/exc_shadow_bank.sv
module exc_shadow_bank #(
  parameter int LANES  = 8,
  parameter int DATA_W = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    swap_fire,
  input  logic [LANES*DATA_W-1:0] live_rd,
  output logic [LANES*DATA_W-1:0] shadow_rd
);
  for (genvar g = 0; g < LANES; g++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n) slot_q <= '0;
      else if (swap_fire) slot_q <= live_rd[g*DATA_W +: DATA_W];
    end
    assign shadow_rd[g*DATA_W +: DATA_W] = slot_q;
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  output logic accept,
  output logic commit,
  output logic entry_done
);
  typedef enum logic {ST_IDLE = 1'b0, ST_COMMIT = 1'b1} st_e;
  st_e st_q;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign commit    = (st_q == ST_COMMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      entry_done <= 1'b0;
    end else begin
      entry_done <= commit;
      st_q       <= accept ? ST_COMMIT : ST_IDLE;
    end
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int PC_W   = 64,
  parameter int DATA_W = 64,
  parameter int LANES  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [CODE_W-1:0]       req_code,
  input  logic [GATE_W-1:0]       req_gate,
  input  logic [PC_W-1:0]         cur_pc,
  input  logic [PC_W-1:0]         fw_base,
  input  logic                    mode_clear,
  input  logic [LANES*DATA_W-1:0] live_rd,
  output logic [LANES*DATA_W-1:0] live_wr,
  output logic                    live_we,
  output logic [LANES*IDX_W-1:0]  swap_idx,
  output logic [PC_W-1:0]         new_pc,
  output logic [PC_W-1:0]         saved_pc,
  output logic                    priv_mode,
  output logic                    entry_done,
  output logic                    unhandled_err
);
  // Named internal events
  logic accept, commit, known, entry_ok, bad_commit, swap_fire;
  logic [CODE_W-1:0] cap_code;
  logic [GATE_W-1:0] cap_gate;
  logic [PC_W-1:0]   cap_pc, target;
  logic [LANES*DATA_W-1:0] shadow_rd;

  exc_entry_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .accept(accept), .commit(commit), .entry_done(entry_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_code <= '0;
      cap_gate <= '0;
      cap_pc   <= '0;
    end else if (accept) begin
      cap_code <= req_code;
      cap_gate <= req_gate;
      cap_pc   <= cur_pc;
    end
  end

  exc_vector_calc #(.PC_W(PC_W)) u_vec (
    .code(cap_code), .gate(cap_gate), .base(fw_base),
    .target(target), .known(known)
  );

  assign entry_ok   = commit && known;
  assign bad_commit = commit && !known;
  assign swap_fire  = entry_ok && !priv_mode;

  exc_shadow_bank #(.LANES(LANES), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .swap_fire(swap_fire),
    .live_rd(live_rd), .shadow_rd(shadow_rd)
  );

  assign live_we = swap_fire;
  assign live_wr = shadow_rd;

  for (genvar g = 0; g < LANES; g++) begin : g_idx
    assign swap_idx[g*IDX_W +: IDX_W] = lane_reg(g);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      new_pc        <= '0;
      saved_pc      <= '0;
      priv_mode     <= 1'b0;
      unhandled_err <= 1'b0;
    end else begin
      if (entry_ok) begin
        new_pc    <= target;
        saved_pc  <= {cap_pc[PC_W-1:1], cap_pc[0] | priv_mode};
        priv_mode <= 1'b1;
      end else if (mode_clear) begin
        priv_mode <= 1'b0;
      end
      if (bad_commit) unhandled_err <= 1'b1;
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int PC_W = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            accept,
  input logic            commit,
  input logic            entry_ok,
  input logic            bad_commit,
  input logic            req_ready,
  input logic            live_we,
  input logic            priv_mode,
  input logic            entry_done,
  input logic            unhandled_err,
  input logic [PC_W-1:0] new_pc,
  input logic [PC_W-1:0] saved_pc
);
  // R8: busy the cycle after accept, done one cycle later
  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  a_r8_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ##1 entry_done);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |=> !entry_done);
  // R6: no exchange while privileged
  a_r6_no_swap_priv: assert property (@(posedge clk) disable iff (!rst_n)
    live_we |-> !priv_mode);
  a_r6_priv_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_ok && priv_mode) |=> priv_mode);
  // R5: exchange only during a commit, and it raises the mode
  a_r5_swap_in_commit: assert property (@(posedge clk) disable iff (!rst_n)
    live_we |-> commit);
  a_r5_priv_after_swap: assert property (@(posedge clk) disable iff (!rst_n)
    live_we |=> priv_mode);
  // R7: sticky error, results held
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unhandled_err |=> unhandled_err);
  a_r7_pc_held: assert property (@(posedge clk) disable iff (!rst_n)
    bad_commit |=> ($stable(new_pc) && $stable(saved_pc) && unhandled_err));
  a_r7_no_swap_bad: assert property (@(posedge clk) disable iff (!rst_n)
    bad_commit |-> !live_we);
endmodule

bind exc_entry_unit exc_entry_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .commit(commit),
  .entry_ok(entry_ok), .bad_commit(bad_commit), .req_ready(req_ready),
  .live_we(live_we), .priv_mode(priv_mode), .entry_done(entry_done),
  .unhandled_err(unhandled_err), .new_pc(new_pc), .saved_pc(saved_pc)
);

// File: tb/tb_exc_entry_unit.sv
module tb_exc_entry_unit;
  localparam int PC_W = 64, DATA_W = 64, LANES = 8;
  localparam int FLAT = LANES * DATA_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, mode_clear = 1'b0;
  logic [3:0] req_code = '0;
  logic [7:0] req_gate = '0;
  logic [PC_W-1:0] cur_pc = '0, fw_base = '0;
  logic [FLAT-1:0] live_rd, live_wr;
  logic live_we, priv_mode, entry_done, unhandled_err;
  logic [LANES*5-1:0] swap_idx;
  logic [PC_W-1:0] new_pc, saved_pc;

  always #5 clk = ~clk;

  exc_entry_unit #(.PC_W(PC_W), .DATA_W(DATA_W), .LANES(LANES)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_code(req_code), .req_gate(req_gate), .cur_pc(cur_pc), .fw_base(fw_base),
    .mode_clear(mode_clear), .live_rd(live_rd), .live_wr(live_wr), .live_we(live_we),
    .swap_idx(swap_idx), .new_pc(new_pc), .saved_pc(saved_pc), .priv_mode(priv_mode),
    .entry_done(entry_done), .unhandled_err(unhandled_err)
  );

  logic [DATA_W-1:0] rf [LANES];
  always_comb for (int k = 0; k < LANES; k++) live_rd[k*DATA_W +: DATA_W] = rf[k];

  typedef struct {
    logic [PC_W-1:0] npc, spc;
    logic priv, err, swap;
    logic [FLAT-1:0] wr;
    int cyc;
    string tag;
  } exp_t;
  exp_t q[$];

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [DATA_W-1:0] m_shadow [LANES];
  logic [PC_W-1:0] m_npc = '0, m_spc = '0;
  logic m_priv = 1'b0, m_err = 1'b0;
  logic seen_swap = 1'b0;
  logic [FLAT-1:0] seen_wr = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic ok, input string tag, input logic [FLAT-1:0] act,
                       input logic [FLAT-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: scoreboard pop on each done pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (live_we) begin
        seen_swap = 1'b1;
        seen_wr = live_wr;
      end
      if (entry_done) begin
        if (q.size() == 0) check(1'b0, "R8 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          check(cyc == e.cyc, {e.tag, " R8 done cycle"}, FLAT'(cyc), FLAT'(e.cyc));
          check(new_pc == e.npc, {e.tag, " new_pc"}, FLAT'(new_pc), FLAT'(e.npc));
          check(saved_pc == e.spc, {e.tag, " R4 saved_pc"}, FLAT'(saved_pc), FLAT'(e.spc));
          check(priv_mode == e.priv, {e.tag, " priv_mode"}, FLAT'(priv_mode), FLAT'(e.priv));
          check(unhandled_err == e.err, {e.tag, " R7 err"}, FLAT'(unhandled_err), FLAT'(e.err));
          check(seen_swap == e.swap, {e.tag, " R5/R6 swap strobe"}, FLAT'(seen_swap), FLAT'(e.swap));
          if (e.swap) check(seen_wr == e.wr, {e.tag, " R5 swap data"}, seen_wr, e.wr);
        end
        seen_swap = 1'b0;
      end
    end
  end

  // Driver: compute expectation independently and push it
  task automatic fire(input logic [3:0] code, input logic [7:0] gate,
                      input logic [PC_W-1:0] pc, input string tag);
    exp_t e;
    logic [PC_W-1:0] off;
    @(negedge clk);
    req_code = code; req_gate = gate; cur_pc = pc; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    e.swap = 1'b0; e.wr = '0; e.tag = tag;
    if (code <= 4'd10) begin
      if (code == 4'd10)
        off = (gate >= 8'h80) ? 64'd8192 + 64'(gate - 8'h80) * 64 : 64'd4096 + 64'(gate) * 64;
      else
        off = 64'(code) * 128;
      m_npc = fw_base + off;
      m_spc = pc | 64'(m_priv);
      if (!m_priv) begin
        e.swap = 1'b1;
        for (int k = 0; k < LANES; k++) begin
          e.wr[k*DATA_W +: DATA_W] = m_shadow[k];
          m_shadow[k] = rf[k];
        end
      end
      m_priv = 1'b1;
    end else begin
      m_err = 1'b1;
    end
    e.npc = m_npc; e.spc = m_spc; e.priv = m_priv; e.err = m_err;
    e.cyc = cyc + 2;
    q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, {tag, " R8 ready low after accept"}, FLAT'(req_ready), 0);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic leave_mode();
    drain();
    mode_clear = 1'b1;
    @(negedge clk);
    mode_clear = 1'b0;
    m_priv = 1'b0;
    check(priv_mode == 1'b0, "R10 mode_clear", FLAT'(priv_mode), 0);
  endtask

  task automatic load_rf(input logic [DATA_W-1:0] seed);
    for (int k = 0; k < LANES; k++) rf[k] = seed ^ (64'(k) * 64'h0101_0101_0101_0101);
  endtask

  task automatic main_seq();
    for (int k = 0; k < LANES; k++) m_shadow[k] = '0;
    load_rf(64'hA5A5_0000_1111_2222);
    fw_base = 64'hFFFF_0000_0040_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(req_ready == 1'b1, "R9 ready", FLAT'(req_ready), 1);
    check(priv_mode == 1'b0, "R9 priv", FLAT'(priv_mode), 0);
    check(unhandled_err == 1'b0, "R9 err", FLAT'(unhandled_err), 0);
    check(new_pc == 0 && saved_pc == 0, "R9 pcs", FLAT'(new_pc), 0);
    check(entry_done == 1'b0 && live_we == 1'b0, "R9 strobes", FLAT'(entry_done), 0);
    for (int k = 0; k < LANES; k++)
      check(swap_idx[k*5 +: 5] == ((k < 7) ? 5'(8 + k) : 5'd25), "R5 swap_idx",
            FLAT'(swap_idx[k*5 +: 5]), FLAT'((k < 7) ? 8 + k : 25));
    // R1/R5 first entry, then nested entries back to back (R6)
    fire(4'd5, 8'h00, 64'h1234_5678_9ABC_DEF0, "R1 R5 memfault first");
    fire(4'd9, 8'h00, 64'h0000_0000_0000_4000, "R1 R6 fpoff nested");
    fire(4'd10, 8'h03, 64'h0000_0000_0000_4100, "R2 gate 3");
    fire(4'd10, 8'h85, 64'h0000_0000_0000_4200, "R3 gate 0x85");
    fire(4'd10, 8'h80, 64'h0000_0000_0000_4300, "R3 gate 0x80");
    fire(4'd10, 8'h7F, 64'h0000_0000_0000_4400, "R2 gate 0x7F");
    fire(4'd10, 8'hFF, 64'h0000_0000_0000_4500, "R3 gate 0xFF");
    fire(4'd0, 8'h00, 64'h0000_0000_0000_4601, "R1 reset vec");
    fire(4'd8, 8'h00, 64'h0000_0000_0000_4700, "R1 arith");
    // R10 leave mode, new register values, second exchange returns the first set
    leave_mode();
    load_rf(64'h5A5A_3333_4444_5555);
    fire(4'd1, 8'h00, 64'h0000_0000_0000_8000, "R10 R5 mchk re-entry");
    // R7 unhandled codes
    fire(4'd12, 8'h00, 64'h0000_0000_0000_9000, "R7 code 12");
    fire(4'd15, 8'h00, 64'h0000_0000_0000_9100, "R7 code 15");
    fire(4'd3, 8'h00, 64'h0000_0000_0000_9201, "R1 R7 clock after err");
    leave_mode();
    load_rf(64'h0F0F_6666_7777_8888);
    fire(4'd2, 8'h00, 64'h0000_0000_0000_A000, "R5 ipi third swap");
    fire(4'd6, 8'h00, 64'h0000_0000_0000_A100, "R1 unaligned nested");
    fire(4'd7, 8'h00, 64'h0000_0000_0000_A200, "R1 badop nested");
    drain();
    check(unhandled_err == 1'b1, "R7 still sticky", FLAT'(unhandled_err), 1);
    check(q.size() == 0, "R8 all results seen", FLAT'(q.size()), 0);
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule